// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps out the column addresses of one SDRAM read or write burst. A start strobe captures a four-bit mode word and a start column on the same clock edge. From the next cycle on, the block presents one column address per clock. It stops when the programmed number of beats has been issued, or earlier when the terminate input is raised. A memory controller uses it beside its command sequencer. The controller pulses the start strobe with the READ or WRITE command and takes the column from `col_o` on every beat while `busy_o` is high.

Every fixed-length burst stays inside an aligned block of columns the size of the burst. Two orderings are supported. Sequential order counts upward and wraps at the block edge. Interleaved order XORs the beat index into the low column bits. A full-page mode walks the whole row in sequential order, wrapping from the top column to column zero, and runs until it is terminated. The column width is a parameter. The default of 8 bits gives 256 columns per row.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Mode bits [2:0] select the burst length. The codes are 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4 and 3'b011 = 8. `busy_o` stays high for exactly that many cycles and is low in the cycle after the final beat.
- R2: Mode bit [3] selects the ordering: 0 for sequential, 1 for interleaved.
- R3: In sequential order, beat k has upper bits equal to the start column's upper bits. Its low log2(length) bits are (start + k) modulo the length, so the burst wraps to the first column of its aligned block.
- R4: In interleaved order, beat k is the start column with its low log2(length) bits XORed with k.
- R5: Code 3'b111 with sequential order is full page. Beat k is (start + k) modulo 2^COL_W, and the burst has no natural end.
- R6: Codes 3'b100, 3'b101 and 3'b110 are reserved, and code 3'b111 with interleaved order is also invalid. Any of these sets `mode_err_o` and runs a single beat at the start column. `mode_err_o` is low for a valid mode, is captured at each start, and holds until the next start.
- R7: `term_i` high at a clock edge with no start ends the burst in progress: `busy_o` is low in the next cycle.
- R8: The start column is captured on the edge where `start_i` is high, and the first beat (that column) appears in the following cycle. A start accepted while busy restarts the sequence from the new column with the new mode.
- R9: `last_o` is high on the final beat of a fixed-length burst, low on all other beats, and never high in full-page mode.
- R10: After reset `busy_o`, `last_o` and `mode_err_o` are low and `col_o` is zero. `col_o` reads zero whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Bits [2:0] burst length code, bit [3] ordering |
| start_i | input | 1 | Start strobe; captures mode_i and start_col_i |
| start_col_i | input | COL_W | Starting column of the burst |
| term_i | input | 1 | Ends the current burst |
| col_o | output | COL_W | Column address of the current beat |
| busy_o | output | 1 | A beat is being presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |
| mode_err_o | output | 1 | The mode captured at the last start was invalid |

## Verification
The embedded properties check on every cycle several fixed rules. The first beat after a start equals the captured column. Bits above the burst block never move between beats. A terminate empties the pipeline in one cycle. The last-beat flag only appears while busy, and an errored mode is always a single-beat burst. What the properties cannot show is the exact address order. The bench scenarios cover this: sequential against interleaved order at each length, wrap at the block edge and at the row end, restart in mid-burst, and the handling of reserved codes.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    // Length codes in mode bits [2:0]
    localparam logic [2:0] LCODE_1    = 3'b000;
    localparam logic [2:0] LCODE_2    = 3'b001;
    localparam logic [2:0] LCODE_4    = 3'b010;
    localparam logic [2:0] LCODE_8    = 3'b011;
    localparam logic [2:0] LCODE_PAGE = 3'b111;

    // Bit position of the ordering select in the mode word
    localparam int ORDER_BIT = 3;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

endpackage

// File: rtl/sdram_colgen_mode_dec.sv
module sdram_colgen_mode_dec
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int LOG_W = 4
) (
    input  logic [3:0]       mode_i,
    output logic [LOG_W-1:0] len_log_o,
    output logic             full_o,
    output order_e           order_o,
    output logic             err_o
);

    logic [2:0] code;
    order_e     req_order;

    always_comb begin
        code      = mode_i[2:0];
        req_order = order_e'(mode_i[ORDER_BIT]);
        len_log_o = '0;
        full_o    = 1'b0;
        order_o   = req_order;
        err_o     = 1'b0;
        unique case (code)
            LCODE_1: len_log_o = LOG_W'(0);
            LCODE_2: len_log_o = LOG_W'(1);
            LCODE_4: len_log_o = LOG_W'(2);
            LCODE_8: len_log_o = LOG_W'(3);
            LCODE_PAGE: begin
                if (req_order == ORD_SEQ) begin
                    len_log_o = LOG_W'(COL_W);
                    full_o    = 1'b1;
                end else begin
                    // full page is sequential only; degrade to one beat
                    err_o   = 1'b1;
                    order_o = ORD_SEQ;
                end
            end
            default: begin
                err_o   = 1'b1;
                order_o = ORD_SEQ;
            end
        endcase
    end

endmodule

// File: rtl/sdram_colgen_addr.sv
module sdram_colgen_addr
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int LOG_W = 4
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [LOG_W-1:0] len_log_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] blk_mask_o,
    output logic [COL_W-1:0] col_o
);

    // Bits below log2(length) move inside the block; the rest stay put
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign blk_mask_o[i] = (LOG_W'(i) < len_log_i);
    end

    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] int_col;

    always_comb begin
        sum     = base_i + beat_i;
        seq_col = (base_i & ~blk_mask_o) | (sum & blk_mask_o);
        int_col = base_i ^ (beat_i & blk_mask_o);
        col_o   = (order_i == ORD_INTLV) ? int_col : seq_col;
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             busy_o,
    output logic             last_o,
    output logic             mode_err_o
);

    localparam int LOG_W = $clog2(COL_W + 1);

    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [LOG_W-1:0] len_log;
        logic             full;
        order_e           order;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    logic [LOG_W-1:0] dec_len_log;
    logic             dec_full;
    order_e           dec_order;
    logic             dec_err;

    sdram_colgen_mode_dec #(.COL_W(COL_W), .LOG_W(LOG_W)) mode_dec_i (
        .mode_i    (mode_i),
        .len_log_o (dec_len_log),
        .full_o    (dec_full),
        .order_o   (dec_order),
        .err_o     (dec_err)
    );

    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] raw_col;

    sdram_colgen_addr #(.COL_W(COL_W), .LOG_W(LOG_W)) addr_i (
        .base_i     (st_q.base),
        .beat_i     (st_q.beat),
        .len_log_i  (st_q.len_log),
        .order_i    (st_q.order),
        .blk_mask_o (blk_mask),
        .col_o      (raw_col)
    );

    logic at_last;

    always_comb begin
        // Final beat of a fixed burst: beat index equals length minus one
        at_last = st_q.busy && !st_q.full && (st_q.beat == blk_mask);
        st_d    = st_q;
        if (start_i) begin
            st_d.busy    = 1'b1;
            st_d.base    = start_col_i;
            st_d.beat    = '0;
            st_d.len_log = dec_len_log;
            st_d.full    = dec_full;
            st_d.order   = dec_order;
            st_d.err     = dec_err;
        end else if (st_q.busy) begin
            if (term_i || at_last) begin
                st_d.busy = 1'b0;
                st_d.beat = '0;
            end else begin
                st_d.beat = st_q.beat + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o      = st_q.busy ? raw_col : '0;
    assign busy_o     = st_q.busy;
    assign last_o     = at_last;
    assign mode_err_o = st_q.err;

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && col_o == $past(start_col_i))); // R8

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> !busy_o); // R7

    AST_LAST_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (busy_o && !st_q.full)); // R9

    AST_ERR_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_err_o) |-> (last_o && col_o == st_q.base)); // R6

    AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(start_i))
            |-> ((col_o & ~blk_mask) == ($past(col_o) & ~blk_mask))); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (col_o == '0 && !last_o)); // R10

endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb_top;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       mode_i = '0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             busy_o;
    logic             last_o;
    logic             mode_err_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .term_i      (term_i),
        .col_o       (col_o),
        .busy_o      (busy_o),
        .last_o      (last_o),
        .mode_err_o  (mode_err_o)
    );

    // {mode[3:0], start[7:0], beats[3:0], expected beats 0..7 from bit 63 down}
    localparam int NVEC = 8;
    localparam logic [79:0] VEC [NVEC] = '{
        {4'b0010, 8'h05, 4'd4, 8'h05, 8'h06, 8'h07, 8'h04, 32'h0},
        {4'b1010, 8'h05, 4'd4, 8'h05, 8'h04, 8'h07, 8'h06, 32'h0},
        {4'b0011, 8'h2B, 4'd8, 8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F, 8'h28, 8'h29, 8'h2A},
        {4'b1011, 8'h2B, 4'd8, 8'h2B, 8'h2A, 8'h29, 8'h28, 8'h2F, 8'h2E, 8'h2D, 8'h2C},
        {4'b0001, 8'hFF, 4'd2, 8'hFF, 8'hFE, 48'h0},
        {4'b1001, 8'h10, 4'd2, 8'h10, 8'h11, 48'h0},
        {4'b0000, 8'h77, 4'd1, 8'h77, 56'h0},
        {4'b1000, 8'h03, 4'd1, 8'h03, 56'h0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive a start at a falling edge; the first beat is visible one cycle later
    task automatic kick(input logic [3:0] m, input logic [7:0] c);
        @(negedge clk);
        mode_i      = m;
        start_col_i = c;
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    initial begin
        #1000000;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "busy", int'(busy_o), 0);
        check("R10", "last", int'(last_o), 0);
        check("R10", "err", int'(mode_err_o), 0);
        check("R10", "col", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 lengths, R2/R3/R4 ordering, R9 last flag, R8 capture
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  m;
            logic [7:0]  c;
            int          n;
            logic [63:0] e;
            m = VEC[v][79:76];
            c = VEC[v][75:68];
            n = int'(VEC[v][67:64]);
            e = VEC[v][63:0];
            kick(m, c);
            for (int k = 0; k < n; k++) begin
                check(m[3] ? "R4" : "R3", "beat col", int'(col_o), int'(e[63 - 8*k -: 8]));
                check("R1", "busy", int'(busy_o), 1);
                check("R9", "last", int'(last_o), (k == n - 1) ? 1 : 0);
                check("R6", "err clear", int'(mode_err_o), 0);
                @(negedge clk);
            end
            check("R1", "busy after end", int'(busy_o), 0);
        end

        // R5 full page wraps the row, R9 no last, R7 terminate
        kick(4'b0111, 8'hFE);
        for (int k = 0; k < 10; k++) begin
            check("R5", "page col", int'(col_o), (254 + k) % 256);
            check("R9", "page last", int'(last_o), 0);
            if (k == 9) term_i = 1'b1;
            @(negedge clk);
        end
        term_i = 1'b0;
        check("R7", "busy after term", int'(busy_o), 0);

        // R7 terminate inside a fixed burst
        kick(4'b0011, 8'h2B);
        @(negedge clk);
        check("R3", "beat1", int'(col_o), 8'h2C);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R7", "busy after term", int'(busy_o), 0);
        check("R7", "col idle", int'(col_o), 0);

        // R8 restart while busy
        kick(4'b0011, 8'h00);
        check("R8", "first", int'(col_o), 0);
        start_col_i = 8'h31;
        mode_i      = 4'b0001;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8", "restart col", int'(col_o), 8'h31);
        check("R9", "restart last0", int'(last_o), 0);
        @(negedge clk);
        check("R3", "restart wrap", int'(col_o), 8'h30);
        check("R9", "restart last1", int'(last_o), 1);
        @(negedge clk);
        check("R8", "restart done", int'(busy_o), 0);

        // R6 reserved codes and interleaved full page
        kick(4'b0101, 8'h44);
        check("R6", "err", int'(mode_err_o), 1);
        check("R6", "col", int'(col_o), 8'h44);
        check("R6", "last", int'(last_o), 1);
        @(negedge clk);
        check("R6", "one beat", int'(busy_o), 0);
        check("R6", "err held", int'(mode_err_o), 1);
        kick(4'b1111, 8'h12);
        check("R6", "err intlv page", int'(mode_err_o), 1);
        check("R6", "col intlv page", int'(col_o), 8'h12);
        @(negedge clk);
        check("R6", "one beat page", int'(busy_o), 0);
        kick(4'b0001, 8'h08);
        check("R6", "err cleared", int'(mode_err_o), 0);
        check("R2", "seq col", int'(col_o), 8'h08);
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule